// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the processor's entry into a handler. Each cycle it looks at a pending exception code (with a valid bit) and a hardware interrupt request. It decides whether entry happens and which kind of entry it is. On the clock edge that accepts an entry, it updates a bank of registers together. The saved status, saved program counter and saved stack pointer are loaded, the new status word is formed, and the handler address is chosen. The event code register for the kind of entry that happened is also written.

An exception always wins over an interrupt that arrives at the same time. When the status word's block bit is set, exceptions are forced to the reset code, except for one exempt code. Interrupts are then ignored unless the core is asleep. For interrupts, the current level mask goes out combinationally to an external controller. The controller answers with a vector, or with no vector, in which case entry is abandoned. The saved program counter is corrected for two cases: entry from a delay slot, and the trap code.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid` and `irq_req` are both high in a cycle, the exception is taken. `expevt` gets the code and `intevt` keeps its old value.
- R2: With status bit 28 (block) set, an exception whose code is not 0x1E0 enters as code 0x000. An interrupt request is ignored, and no register changes, unless `sleeping` is high.
- R3: `irq_level` always equals status bits 7:4. An interrupt with `intc_vec_valid` low produces no entry and no register change.
- R4: On every entry, `ssr` gets the old status, `sgr` gets `cur_r15`, and `new_sr` is the old status with bits 28, 29 and 30 set. Only R6 modifies any other bit.
- R5: When `in_dslot` is high at entry, `spc` gets PC minus 2 and `dslot_clr` pulses for one cycle. Otherwise `spc` gets the PC.
- R6: Codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits 7:4 to 0xF, and set `new_pc` to 0xA0000000.
- R7: Codes 0x040 and 0x060 set `new_pc` to VBR+0x400. Every other exception code sets it to VBR+0x100.
- R8: Code 0x160 adds 2 to the saved PC. This is applied after any delay-slot correction.
- R9: An accepted interrupt loads `intc_vector` into `intevt` and sets `new_pc` to VBR+0x600. `expevt` is not changed.
- R10: `wake` pulses for one cycle after any exception, and after any interrupt that the block bit does not mask. This includes an interrupt that is abandoned for lack of a vector.
- R11: `taken` is high only in the cycle after an accepted request, and all registers change on that same edge. All registers and pulses are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cur_pc | input | 32 | program counter at the faulting point |
| cur_sr | input | 32 | current status word |
| cur_r15 | input | 32 | current stack pointer |
| vbr | input | 32 | vector base |
| in_dslot | input | 1 | an instruction in a delay slot is executing |
| sleeping | input | 1 | core is in sleep |
| exc_valid | input | 1 | an exception is pending |
| exc_code | input | 12 | pending exception code |
| irq_req | input | 1 | hardware interrupt request |
| irq_level | output | 4 | level mask sent to the interrupt controller |
| intc_vec_valid | input | 1 | controller returned a vector |
| intc_vector | input | 12 | vector from the controller |
| taken | output | 1 | entry performed (one-cycle pulse) |
| wake | output | 1 | leave-sleep pulse |
| dslot_clr | output | 1 | clear delay-slot flags pulse |
| new_pc | output | 32 | handler address |
| new_sr | output | 32 | status word after entry |
| ssr | output | 32 | saved status |
| spc | output | 32 | saved program counter |
| sgr | output | 32 | saved stack pointer |
| expevt | output | 12 | last exception code |
| intevt | output | 12 | last interrupt vector |

## Verification
The bench sweeps every distinguished exception code against every combination of the block bit and the delay-slot flag. In odd steps it also raises an interrupt at the same time. A design with the exemption check inverted would reset on code 0x1E0 under block. A design with the wrong arbitration order would overwrite `intevt`. The interrupt sweep crosses the block bit, sleep and vector presence. It catches interrupts that slip through while blocked, and entries made without a vector. It also catches a `wake` that is tied to `taken` rather than to the masking decision. A trap taken in a delay slot checks that both corrections are applied, so a design that picks only one of them is exposed.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // status word bit positions the entry sequence manipulates
  localparam int SR_BLOCK   = 28;
  localparam int SR_REGBANK = 29;
  localparam int SR_PRIV    = 30;
  localparam int SR_FPUOFF  = 15;
  localparam int SR_MASK_LO = 4;
  localparam int SR_MASK_W  = 4;

  // exception codes with distinct handling
  localparam int EC_POWERON  = 'h000;
  localparam int EC_MANRESET = 'h020;
  localparam int EC_MULTIHIT = 'h140;
  localparam int EC_MISS_RD  = 'h040;
  localparam int EC_MISS_WR  = 'h060;
  localparam int EC_TRAP     = 'h160;
  localparam int EC_EXEMPT   = 'h1E0;

  typedef enum logic [1:0] {
    DEST_RESET   = 2'd0,
    DEST_TLBMISS = 2'd1,
    DEST_GENERAL = 2'd2,
    DEST_IRQ     = 2'd3
  } dest_e;

endpackage

// File: rtl/entry_arbiter.sv
module entry_arbiter
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              sleeping,
  input  logic              blocked,
  input  logic              vec_valid,
  output logic              go_exc,
  output logic              go_irq,
  output logic              wake,
  output logic [CODE_W-1:0] eff_code
);

  logic irq_want;
  logic irq_masked;
  logic exempt_hit;

  always_comb begin
    // exceptions always win over a simultaneous interrupt
    go_exc     = exc_valid;
    irq_want   = irq_req & ~exc_valid;
    // blocked state drops interrupts unless asleep
    irq_masked = irq_want & blocked & ~sleeping;
    go_irq     = irq_want & ~irq_masked & vec_valid;
    // sleep is left before the vector lookup result matters
    wake       = go_exc | (irq_want & ~irq_masked);
    exempt_hit = (exc_code == CODE_W'(EC_EXEMPT));
    eff_code   = (exc_valid & blocked & ~exempt_hit) ? CODE_W'(EC_POWERON) : exc_code;
  end

endmodule

// File: rtl/entry_target.sv
module entry_target
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter int          OFS_GEN  = 'h100,
  parameter int          OFS_TLB  = 'h400,
  parameter int          OFS_IRQ  = 'h600,
  parameter int          INSN_B   = 2
) (
  input  logic              go_exc,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_dslot,
  output dest_e             dest,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [XLEN-1:0]   nxt_sr,
  output logic [XLEN-1:0]   nxt_spc
);

  function automatic dest_e classify(input logic [CODE_W-1:0] c);
    dest_e d;
    if (c == CODE_W'(EC_POWERON) || c == CODE_W'(EC_MANRESET) || c == CODE_W'(EC_MULTIHIT))
      d = DEST_RESET;
    else if (c == CODE_W'(EC_MISS_RD) || c == CODE_W'(EC_MISS_WR))
      d = DEST_TLBMISS;
    else
      d = DEST_GENERAL;
    return d;
  endfunction

  function automatic logic [XLEN-1:0] handler_addr(input dest_e d, input logic [XLEN-1:0] base);
    logic [XLEN-1:0] a;
    case (d)
      DEST_RESET:   a = XLEN'(RESET_PC);
      DEST_TLBMISS: a = base + XLEN'(OFS_TLB);
      DEST_IRQ:     a = base + XLEN'(OFS_IRQ);
      default:      a = base + XLEN'(OFS_GEN);
    endcase
    return a;
  endfunction

  function automatic logic [XLEN-1:0] return_addr(input logic [XLEN-1:0] pc, input logic ds,
                                                  input logic trap);
    logic [XLEN-1:0] r;
    r = pc;
    if (ds)   r = r - XLEN'(INSN_B);
    if (trap) r = r + XLEN'(INSN_B);
    return r;
  endfunction

  function automatic logic [XLEN-1:0] entered_sr(input logic [XLEN-1:0] sr, input logic rst_cls);
    logic [XLEN-1:0] s;
    s = sr;
    s[SR_BLOCK]   = 1'b1;
    s[SR_REGBANK] = 1'b1;
    s[SR_PRIV]    = 1'b1;
    if (rst_cls) begin
      s[SR_FPUOFF] = 1'b0;
      s[SR_MASK_LO +: SR_MASK_W] = '1;
    end
    return s;
  endfunction

  logic is_trap;

  always_comb begin
    dest    = go_exc ? classify(eff_code) : DEST_IRQ;
    is_trap = go_exc & (eff_code == CODE_W'(EC_TRAP));
    nxt_pc  = handler_addr(dest, vbr);
    nxt_sr  = entered_sr(cur_sr, dest == DEST_RESET);
    nxt_spc = return_addr(cur_pc, in_dslot, is_trap);
  end

endmodule

// File: rtl/entry_bank.sv
module entry_bank #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_exc,
  input  logic              ld_irq,
  input  logic              wake_in,
  input  logic              ds_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   ssr_in,
  input  logic [XLEN-1:0]   spc_in,
  input  logic [XLEN-1:0]   sgr_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CODE_W-1:0] vec_in,
  output logic              taken,
  output logic              wake,
  output logic              dslot_clr,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);

  logic ld_any;
  assign ld_any = ld_exc | ld_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken     <= 1'b0;
      wake      <= 1'b0;
      dslot_clr <= 1'b0;
      new_pc    <= '0;
      new_sr    <= '0;
      ssr       <= '0;
      spc       <= '0;
      sgr       <= '0;
      expevt    <= '0;
      intevt    <= '0;
    end else begin
      taken     <= ld_any;
      wake      <= wake_in;
      dslot_clr <= ld_any & ds_in;
      if (ld_any) begin
        new_pc <= pc_in;
        new_sr <= sr_in;
        ssr    <= ssr_in;
        spc    <= spc_in;
        sgr    <= sgr_in;
      end
      if (ld_exc) expevt <= code_in;
      if (ld_irq) intevt <= vec_in;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_dslot,
  input  logic              sleeping,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  output logic [3:0]        irq_level,
  input  logic              intc_vec_valid,
  input  logic [CODE_W-1:0] intc_vector,
  output logic              taken,
  output logic              wake,
  output logic              dslot_clr,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);

  // named internal events
  logic              ev_go_exc;
  logic              ev_go_irq;
  logic              ev_wake;
  logic [CODE_W-1:0] ev_code;
  dest_e             ev_dest;
  logic [XLEN-1:0]   calc_pc;
  logic [XLEN-1:0]   calc_sr;
  logic [XLEN-1:0]   calc_spc;

  assign irq_level = cur_sr[SR_MASK_LO +: SR_MASK_W];

  entry_arbiter #(.CODE_W(CODE_W)) u_arb (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .irq_req   (irq_req),
    .sleeping  (sleeping),
    .blocked   (cur_sr[SR_BLOCK]),
    .vec_valid (intc_vec_valid),
    .go_exc    (ev_go_exc),
    .go_irq    (ev_go_irq),
    .wake      (ev_wake),
    .eff_code  (ev_code)
  );

  entry_target #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_PC(RESET_PC)) u_tgt (
    .go_exc   (ev_go_exc),
    .eff_code (ev_code),
    .cur_pc   (cur_pc),
    .cur_sr   (cur_sr),
    .vbr      (vbr),
    .in_dslot (in_dslot),
    .dest     (ev_dest),
    .nxt_pc   (calc_pc),
    .nxt_sr   (calc_sr),
    .nxt_spc  (calc_spc)
  );

  entry_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_exc    (ev_go_exc),
    .ld_irq    (ev_go_irq),
    .wake_in   (ev_wake),
    .ds_in     (in_dslot),
    .pc_in     (calc_pc),
    .sr_in     (calc_sr),
    .ssr_in    (cur_sr),
    .spc_in    (calc_spc),
    .sgr_in    (cur_r15),
    .code_in   (ev_code),
    .vec_in    (intc_vector),
    .taken     (taken),
    .wake      (wake),
    .dslot_clr (dslot_clr),
    .new_pc    (new_pc),
    .new_sr    (new_sr),
    .ssr       (ssr),
    .spc       (spc),
    .sgr       (sgr),
    .expevt    (expevt),
    .intevt    (intevt)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   cur_pc,
  input logic [XLEN-1:0]   cur_sr,
  input logic [XLEN-1:0]   cur_r15,
  input logic [XLEN-1:0]   vbr,
  input logic              in_dslot,
  input logic              sleeping,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic              irq_req,
  input logic              intc_vec_valid,
  input logic [CODE_W-1:0] intc_vector,
  input logic              taken,
  input logic              dslot_clr,
  input logic [XLEN-1:0]   new_pc,
  input logic [XLEN-1:0]   new_sr,
  input logic [XLEN-1:0]   ssr,
  input logic [XLEN-1:0]   sgr,
  input logic [CODE_W-1:0] expevt,
  input logic [CODE_W-1:0] intevt
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(exc_valid && irq_req) |-> taken && $stable(intevt)); // R1

  AST_BLOCK_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(exc_valid && cur_sr[28] && exc_code != 12'h1E0) |-> expevt == '0 && new_pc == 32'hA000_0000); // R2

  AST_BLOCK_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(!exc_valid && irq_req && cur_sr[28] && !sleeping) |-> !taken && $stable(ssr)); // R2

  AST_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(!exc_valid && irq_req && !intc_vec_valid) |-> !taken && $stable(new_pc)); // R3

  AST_SAVED_STATE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    taken |-> ssr == $past(cur_sr) && sgr == $past(cur_r15) && new_sr[30:28] == 3'b111); // R4

  AST_DSLOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    dslot_clr |-> taken && $past(in_dslot)); // R5

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(!exc_valid && irq_req && intc_vec_valid && (!cur_sr[28] || sleeping))
      |-> taken && intevt == $past(intc_vector) && new_pc == $past(vbr) + 32'h600 && $stable(expevt)); // R9

  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(!exc_valid && !irq_req) |-> !taken && $stable(new_sr) && $stable(expevt)); // R11

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0, cur_sr = '0, cur_r15 = '0, vbr = '0;
  logic        in_dslot = 1'b0, sleeping = 1'b0, exc_valid = 1'b0, irq_req = 1'b0;
  logic [11:0] exc_code = '0, intc_vector = '0;
  logic        intc_vec_valid = 1'b0;
  logic [3:0]  irq_level;
  logic        taken, wake, dslot_clr;
  logic [31:0] new_pc, new_sr, ssr, spc, sgr;
  logic [11:0] expevt, intevt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model of the architectural state
  logic [31:0] m_pc = '0, m_sr = '0, m_ssr = '0, m_spc = '0, m_sgr = '0;
  logic [11:0] m_exp = '0, m_int = '0;

  always #2 clk = ~clk;

  exc_entry_seq dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_valid = 1'b0; irq_req = 1'b0; intc_vec_valid = 1'b0; in_dslot = 1'b0; sleeping = 1'b0;
  endtask

  // drive one request, let one edge pass, compare everything against the model
  task automatic one_case(input logic ev, input logic [11:0] code, input logic irq,
                          input logic vv, input logic [11:0] vec, input logic [31:0] sr,
                          input logic [31:0] pc, input logic [31:0] r15, input logic [31:0] vb,
                          input logic ds, input logic slp);
    logic bl, e_take, e_wake, e_exc, rcls;
    logic [11:0] c;
    @(negedge clk);
    exc_valid = ev; exc_code = code; irq_req = irq; intc_vec_valid = vv; intc_vector = vec;
    cur_sr = sr; cur_pc = pc; cur_r15 = r15; vbr = vb; in_dslot = ds; sleeping = slp;
    #1 chk("R3 irq_level", {28'd0, irq_level}, {28'd0, sr[7:4]});
    bl = sr[28];
    e_exc = ev;
    c = (ev && bl && code != 12'h1E0) ? 12'h000 : code;
    if (ev) begin
      e_take = 1'b1; e_wake = 1'b1;
    end else if (irq) begin
      e_wake = !(bl && !slp);
      e_take = e_wake && vv;
    end else begin
      e_take = 1'b0; e_wake = 1'b0;
    end
    if (e_take) begin
      m_ssr = sr; m_sgr = r15;
      m_spc = ds ? pc - 32'd2 : pc;
      m_sr  = sr | 32'h7000_0000;
      if (e_exc) begin
        m_exp = c;
        rcls = (c == 12'h000) || (c == 12'h020) || (c == 12'h140);
        if (rcls) begin
          m_sr[15] = 1'b0; m_sr[7:4] = 4'hF; m_pc = 32'hA000_0000;
        end else if (c == 12'h040 || c == 12'h060) begin
          m_pc = vb + 32'h400;
        end else begin
          m_pc = vb + 32'h100;
          if (c == 12'h160) m_spc = m_spc + 32'd2;
        end
      end else begin
        m_int = vec; m_pc = vb + 32'h600;
      end
    end
    @(negedge clk);
    idle_inputs();
    chk("R11 taken", {31'd0, taken}, {31'd0, e_take});
    chk("R10 wake", {31'd0, wake}, {31'd0, e_wake});
    chk("R5 dslot_clr", {31'd0, dslot_clr}, {31'd0, e_take & ds});
    chk("R4 ssr", ssr, m_ssr);
    chk("R4 sgr", sgr, m_sgr);
    chk("R4 R6 new_sr", new_sr, m_sr);
    chk("R5 R8 spc", spc, m_spc);
    chk("R6 R7 R9 new_pc", new_pc, m_pc);
    chk("R1 R2 expevt", {20'd0, expevt}, {20'd0, m_exp});
    chk("R1 R9 intevt", {20'd0, intevt}, {20'd0, m_int});
    // pulses last one cycle only
    @(negedge clk);
    chk("R11 taken pulse ends", {31'd0, taken}, 32'd0);
    chk("R10 wake pulse ends", {31'd0, wake}, 32'd0);
  endtask

  initial begin
    logic [11:0] codes [16];
    codes = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h080, 12'h0A0, 12'h0C0, 12'h0E0,
              12'h100, 12'h120, 12'h140, 12'h160, 12'h180, 12'h1A0, 12'h1E0, 12'h800};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset taken", {31'd0, taken}, 32'd0);
    chk("R11 reset new_pc", new_pc, 32'd0);
    chk("R11 reset ssr", ssr, 32'd0);
    chk("R11 reset expevt", {20'd0, expevt}, 32'd0);
    rst_n = 1'b1;
    // exception sweep: every code x block x delay slot, with a racing irq on odd steps (R1 R2 R5 R6 R7 R8)
    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 16; i++) begin
          logic [31:0] s;
          s = 32'h0000_8000 | (32'(i) << 4) | (32'(b) << 28) | 32'h0000_0003;
          one_case(1'b1, codes[i], i[0], 1'b1, 12'h3C0 + 12'(i), s,
                   32'h0C00_1000 + 32'(i) * 32'h24, 32'h8C0F_F000 - 32'(i),
                   32'h8C00_0000 + 32'(i) * 32'h1000, d[0], b[0] & i[1]);
        end
    // interrupt sweep: block x sleep x vector present x masks (R2 R3 R9 R10)
    for (int b = 0; b < 2; b++)
      for (int sl = 0; sl < 2; sl++)
        for (int v = 0; v < 2; v++)
          for (int m = 0; m < 3; m++) begin
            logic [31:0] s;
            s = 32'h0000_8000 | (32'(m * 7) << 4) | (32'(b) << 28);
            one_case(1'b0, 12'h000, 1'b1, v[0], 12'h200 + 12'(m * 32 + b * 4 + sl),
                     s, 32'h0C00_4000 + 32'(m) * 32'h10, 32'h8C0E_0000 + 32'(m),
                     32'h8C10_0000 + 32'(b) * 32'h100, m[0], sl[0]);
          end
    // no request at all leaves everything unchanged (R11)
    one_case(1'b0, 12'h0E0, 1'b0, 1'b1, 12'h5A0, 32'h1000_00F0, 32'h1234_5678,
             32'h1, 32'h2, 1'b1, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule